// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sequences interrupt entry and return for a small pipelined microcontroller core. It watches a pending-request line, a global enable flag and a busy indication from multi-cycle blocking instructions. When it takes a request, it clears the global enable and moves the core to a dedicated interrupt speed code. The speed code that was in force is saved on a two-entry shadow stack. After a fixed number of core cycles it pulses a vector-fetch strobe together with the current vector address.

A return strobe arrives together with a 3-bit option field, the return PC and the working-register value. The option bits can pull the saved speed code back from the shadow stack. They can reload the vector register with the return PC plus one, so the next interrupt continues right after this return. They can also ask the timer to add the working-register value. A return always turns global enable back on. Mainline code resumes only after the return cycle and two pipeline-refill cycles have passed.

Top module: `irq_seq_top`

## Requirements
- R1: With `gie`=1, `core_busy`=0 and the sequencer idle or in a handler, a high `irq_pend` is taken on the rising edge that samples it. `vec_fetch` goes high for exactly one cycle after the third rising edge, counting the sampling edge as the first. While it is high, `vec_addr` shows the vector register.
- R2: When `irq_portb`=1 and `sync_on`=0 at the sampling edge, `vec_fetch` comes two edges later (after the fifth edge). When `sync_on`=1 the latency stays at three edges.
- R3: No request is taken on an edge where `core_busy`=1. A request held through a busy period is taken on the first edge that sees `core_busy`=0.
- R4: After the edge that takes a request, `gie` reads 0, `spd_code` equals `int_spd`, the old speed code is on the shadow stack, and `nest_depth` has gone up by one. Writes to `gie` are ignored while entry or return is in progress.
- R5: A request is never taken while `gie`=0. Inside a handler, a nested request is taken only after the handler sets `gie` again.
- R6: The shadow stack holds two entries. A request that meets all other conditions while it is full sets the sticky `stack_ovf` flag. It produces no `vec_fetch`, leaves `nest_depth` at 2, and leaves both saved speed codes intact.
- R7: A return taken inside a handler sets `gie` to 1 after its edge, even if the handler cleared `gie` before.
- R8: Return option bit 2 = 1 loads `spd_code` from the newest shadow entry. Bit 2 = 0 keeps the interrupt speed code. Either way the entry is popped.
- R9: Return option bit 1 = 1 loads the vector register with `ret_pc`+1, wrapping modulo 2^PCW. Bit 1 = 0 leaves it unchanged. `vec_wr` loads it directly with `vec_wdata`, and it resets to `RST_VEC`.
- R10: Return option bit 0 = 1 pulses `tmr_add_valid` for one cycle right after the return edge, with `tmr_add_val` = `w_val`. Bit 0 = 0 produces no pulse.
- R11: `mainline_resume` pulses for one cycle after the third edge counting the return edge. No request is taken before the edge that follows that pulse; a request held pending through the window is taken one edge later.
- R12: A `ret_valid` outside a handler (`nest_depth`=0) is ignored. `gie`, `spd_code`, `vec_addr` and `nest_depth` stay unchanged and no timer pulse is issued.
- R13: After reset, `gie`=0, `spd_code`=`RST_SPD`, `vec_addr`=`RST_VEC`, `nest_depth`=0, and `stack_ovf`, `vec_fetch`, `mainline_resume` and `tmr_add_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pend | input | 1 | Some enabled interrupt source is pending |
| irq_portb | input | 1 | Pending source comes through the port-B input path |
| sync_on | input | 1 | Input-synchronizer option; 0 adds two cycles for port-B sources |
| core_busy | input | 1 | Multi-cycle blocking instruction in progress |
| gie_set | input | 1 | Handler or mainline sets global enable |
| gie_clr | input | 1 | Handler or mainline clears global enable (wins over set) |
| spd_wr | input | 1 | Write strobe for the speed code |
| spd_wdata | input | SPW | Speed code to write |
| int_spd | input | SPW | Speed code used while servicing interrupts |
| vec_wr | input | 1 | Write strobe for the vector register |
| vec_wdata | input | PCW | Vector value to write |
| ret_valid | input | 1 | Return-from-interrupt executes this cycle |
| ret_opt | input | 3 | Return options: bit 2 restore speed, bit 1 vector=PC+1, bit 0 timer add |
| ret_pc | input | PCW | PC of the return instruction |
| w_val | input | DW | Working-register value |
| gie | output | 1 | Global interrupt enable |
| spd_code | output | SPW | Active core speed code |
| vec_addr | output | PCW | Interrupt vector register |
| vec_fetch | output | 1 | First handler instruction reaches execute |
| mainline_resume | output | 1 | Refill finished, interrupted code resumes next cycle |
| tmr_add_valid | output | 1 | Timer-add request |
| tmr_add_val | output | DW | Value to add to the timer |
| nest_depth | output | DPW | Entries held on the shadow stack |
| stack_ovf | output | 1 | Sticky shadow-stack overflow flag |

## Verification
The bench measures entry latency exactly on each path. It covers the plain case and the slow port-B path with the synchronizer option off and on, which catches a design whose fetch strobe comes one edge early or late. It also holds a request across a four-cycle busy period, which catches a design that takes the request during a blocking instruction. It nests to the full depth and then fires a third request. A stack that overwrote an entry would show up when two speed-restoring returns do not bring back the interrupt code first and the mainline code second. It raises a request in the same cycle as a return and expects the fetch only after the refill window, which catches a design that sneaks an entry in early. The vector reload is driven with an all-ones PC to expose a missing wrap. A return outside any handler must leave every output alone, which catches a design that pops an empty stack or pulses the timer.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ENTRY = 2'd1,
        ST_ISR   = 2'd2,
        ST_RET   = 2'd3
    } seq_state_e;

    localparam int OPT_SPD_RESTORE = 2;
    localparam int OPT_VEC_RELOAD  = 1;
    localparam int OPT_TMR_ADD     = 0;

endpackage

// File: rtl/irq_lat_calc.sv
module irq_lat_calc #(
    parameter int BASE_LAT = 3,
    parameter int SYNC_LAT = 2,
    parameter int CW       = 3
) (
    input  logic          irq_portb,
    input  logic          sync_on,
    output logic [CW-1:0] lat_load
);
    localparam logic [CW-1:0] BASE_LOAD = CW'(BASE_LAT - 1);
    localparam logic [CW-1:0] SLOW_ADD  = CW'(SYNC_LAT);

    logic slow_path;

    always_comb begin
        slow_path = irq_portb && !sync_on;
        lat_load  = BASE_LOAD;
        if (slow_path) begin
            lat_load = BASE_LOAD + SLOW_ADD;
        end
    end

endmodule

// File: rtl/irq_shadow_stack.sv
module irq_shadow_stack #(
    parameter int DEPTH = 2,
    parameter int W     = 4,
    parameter int DPW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    input  logic [W-1:0]   push_data,
    output logic [W-1:0]   top_data,
    output logic [DPW-1:0] depth,
    output logic           full,
    output logic           ovf
);
    localparam logic [DPW-1:0] DEPTH_MAX = DPW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
        logic [DPW-1:0]          dep;
        logic                    ovf;
    } stk_t;

    stk_t stk_q, stk_d;
    logic [DEPTH-1:0] wr_sel;
    logic [DEPTH-1:0] top_sel;

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_sel
            assign wr_sel[gi]  = push && !pop && (stk_q.dep == DPW'(gi));
            assign top_sel[gi] = (stk_q.dep == DPW'(gi + 1));
        end
    endgenerate

    always_comb begin
        stk_d = stk_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_sel[i]) begin
                stk_d.ent[i] = push_data;
            end
        end
        if (push && !pop) begin
            if (stk_q.dep < DEPTH_MAX) begin
                stk_d.dep = stk_q.dep + 1'b1;
            end else begin
                stk_d.ovf = 1'b1;
            end
        end else if (pop && !push) begin
            if (stk_q.dep != '0) begin
                stk_d.dep = stk_q.dep - 1'b1;
            end
        end
    end

    always_comb begin
        top_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (top_sel[i]) begin
                top_data = stk_q.ent[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    assign depth = stk_q.dep;
    assign full  = (stk_q.dep == DEPTH_MAX);
    assign ovf   = stk_q.ovf;

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DEPTH_MAX); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> (depth == DEPTH_MAX && $stable(stk_q.ent))); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R6

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
#(
    parameter int PCW      = 16,
    parameter int SPW      = 4,
    parameter int DW       = 8,
    parameter int CW       = 3,
    parameter int DPW      = 2,
    parameter int REFILL   = 2,
    parameter logic [SPW-1:0] RST_SPD = '0,
    parameter logic [PCW-1:0] RST_VEC = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           irq_pend,
    input  logic           core_busy,
    input  logic [CW-1:0]  lat_load,
    input  logic           gie_set,
    input  logic           gie_clr,
    input  logic           spd_wr,
    input  logic [SPW-1:0] spd_wdata,
    input  logic [SPW-1:0] int_spd,
    input  logic           vec_wr,
    input  logic [PCW-1:0] vec_wdata,
    input  logic           ret_valid,
    input  logic [2:0]     ret_opt,
    input  logic [PCW-1:0] ret_pc,
    input  logic [DW-1:0]  w_val,
    input  logic           stk_full,
    input  logic [DPW-1:0] stk_depth,
    input  logic [SPW-1:0] stk_top,
    output logic           stk_push,
    output logic           stk_pop,
    output logic [SPW-1:0] stk_push_data,
    output logic           gie,
    output logic [SPW-1:0] spd_code,
    output logic [PCW-1:0] vec_addr,
    output logic           vec_fetch,
    output logic           mainline_resume,
    output logic           tmr_add_valid,
    output logic [DW-1:0]  tmr_add_val
);
    localparam logic [CW-1:0]  REFILL_LOAD = CW'(REFILL);
    localparam logic [PCW-1:0] PC_ONE      = PCW'(1);

    typedef struct packed {
        seq_state_e     st;
        logic [CW-1:0]  cnt;
        logic           gie;
        logic [SPW-1:0] spd;
        logic [PCW-1:0] vec;
        logic           tmr_v;
        logic [DW-1:0]  tmr_val;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic can_take;
    logic ret_take;
    logic in_slot;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.tmr_v = 1'b0;
        stk_push    = 1'b0;
        stk_pop     = 1'b0;

        in_slot  = (ctl_q.st == ST_IDLE) || (ctl_q.st == ST_ISR);
        ret_take = (ctl_q.st == ST_ISR) && ret_valid;
        can_take = in_slot && irq_pend && ctl_q.gie && !core_busy && !ret_take;

        if (in_slot) begin
            if (gie_set) ctl_d.gie = 1'b1;
            if (gie_clr) ctl_d.gie = 1'b0;
        end
        if (spd_wr) ctl_d.spd = spd_wdata;
        if (vec_wr) ctl_d.vec = vec_wdata;

        unique case (ctl_q.st)
            ST_IDLE, ST_ISR: begin
                if (ret_take) begin
                    stk_pop     = 1'b1;
                    ctl_d.st    = ST_RET;
                    ctl_d.cnt   = REFILL_LOAD;
                    ctl_d.gie   = 1'b1;
                    if (ret_opt[OPT_SPD_RESTORE]) ctl_d.spd = stk_top;
                    if (ret_opt[OPT_VEC_RELOAD])  ctl_d.vec = ret_pc + PC_ONE;
                    if (ret_opt[OPT_TMR_ADD]) begin
                        ctl_d.tmr_v   = 1'b1;
                        ctl_d.tmr_val = w_val;
                    end
                end else if (can_take) begin
                    stk_push = 1'b1;
                    if (!stk_full) begin
                        ctl_d.st  = ST_ENTRY;
                        ctl_d.cnt = lat_load;
                        ctl_d.gie = 1'b0;
                        ctl_d.spd = int_spd;
                    end
                end
            end
            ST_ENTRY: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st = ST_ISR;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_RET: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st = (stk_depth != '0) ? ST_ISR : ST_IDLE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_IDLE;
            ctl_q.spd   <= RST_SPD;
            ctl_q.vec   <= RST_VEC;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign stk_push_data   = ctl_q.spd;
    assign gie             = ctl_q.gie;
    assign spd_code        = ctl_q.spd;
    assign vec_addr        = ctl_q.vec;
    assign vec_fetch       = (ctl_q.st == ST_ENTRY) && (ctl_q.cnt == '0);
    assign mainline_resume = (ctl_q.st == ST_RET) && (ctl_q.cnt == '0);
    assign tmr_add_valid   = ctl_q.tmr_v;
    assign tmr_add_val     = ctl_q.tmr_val;

    AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_fetch |=> !vec_fetch); // R1
    AST_NO_ENTRY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ENTRY && $past(ctl_q.st) != ST_ENTRY) |-> !$past(core_busy)); // R3
    AST_ENTRY_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ENTRY && $past(ctl_q.st) != ST_ENTRY) |-> (spd_code == $past(int_spd) && !gie)); // R4
    AST_ENTRY_GIE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ENTRY) |-> !gie); // R4
    AST_NEED_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ENTRY && $past(ctl_q.st) != ST_ENTRY) |-> $past(gie)); // R5
    AST_RET_GIE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ISR && ret_valid) |=> gie); // R7
    AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mainline_resume |=> (ctl_q.st != ST_RET)); // R11
    AST_NO_TAKE_IN_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RET) |=> (ctl_q.st != ST_ENTRY)); // R11
    AST_TMR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_add_valid |=> !tmr_add_valid); // R10

endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top #(
    parameter int PCW      = 16,
    parameter int SPW      = 4,
    parameter int DW       = 8,
    parameter int SDEPTH   = 2,
    parameter int BASE_LAT = 3,
    parameter int SYNC_LAT = 2,
    parameter int REFILL   = 2,
    parameter logic [SPW-1:0] RST_SPD = 4'h7,
    parameter logic [PCW-1:0] RST_VEC = 16'h0040,
    parameter int DPW      = $clog2(SDEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           irq_pend,
    input  logic           irq_portb,
    input  logic           sync_on,
    input  logic           core_busy,
    input  logic           gie_set,
    input  logic           gie_clr,
    input  logic           spd_wr,
    input  logic [SPW-1:0] spd_wdata,
    input  logic [SPW-1:0] int_spd,
    input  logic           vec_wr,
    input  logic [PCW-1:0] vec_wdata,
    input  logic           ret_valid,
    input  logic [2:0]     ret_opt,
    input  logic [PCW-1:0] ret_pc,
    input  logic [DW-1:0]  w_val,
    output logic           gie,
    output logic [SPW-1:0] spd_code,
    output logic [PCW-1:0] vec_addr,
    output logic           vec_fetch,
    output logic           mainline_resume,
    output logic           tmr_add_valid,
    output logic [DW-1:0]  tmr_add_val,
    output logic [DPW-1:0] nest_depth,
    output logic           stack_ovf
);
    localparam int MAXCNT = BASE_LAT + SYNC_LAT + REFILL;
    localparam int CW     = $clog2(MAXCNT + 1);

    logic [CW-1:0]  lat_load;
    logic           stk_push;
    logic           stk_pop;
    logic [SPW-1:0] stk_push_data;
    logic [SPW-1:0] stk_top;
    logic           stk_full;

    irq_lat_calc #(
        .BASE_LAT (BASE_LAT),
        .SYNC_LAT (SYNC_LAT),
        .CW       (CW)
    ) u_lat (
        .irq_portb (irq_portb),
        .sync_on   (sync_on),
        .lat_load  (lat_load)
    );

    irq_shadow_stack #(
        .DEPTH (SDEPTH),
        .W     (SPW),
        .DPW   (DPW)
    ) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_data (stk_push_data),
        .top_data  (stk_top),
        .depth     (nest_depth),
        .full      (stk_full),
        .ovf       (stack_ovf)
    );

    irq_seq_fsm #(
        .PCW     (PCW),
        .SPW     (SPW),
        .DW      (DW),
        .CW      (CW),
        .DPW     (DPW),
        .REFILL  (REFILL),
        .RST_SPD (RST_SPD),
        .RST_VEC (RST_VEC)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .irq_pend        (irq_pend),
        .core_busy       (core_busy),
        .lat_load        (lat_load),
        .gie_set         (gie_set),
        .gie_clr         (gie_clr),
        .spd_wr          (spd_wr),
        .spd_wdata       (spd_wdata),
        .int_spd         (int_spd),
        .vec_wr          (vec_wr),
        .vec_wdata       (vec_wdata),
        .ret_valid       (ret_valid),
        .ret_opt         (ret_opt),
        .ret_pc          (ret_pc),
        .w_val           (w_val),
        .stk_full        (stk_full),
        .stk_depth       (nest_depth),
        .stk_top         (stk_top),
        .stk_push        (stk_push),
        .stk_pop         (stk_pop),
        .stk_push_data   (stk_push_data),
        .gie             (gie),
        .spd_code        (spd_code),
        .vec_addr        (vec_addr),
        .vec_fetch       (vec_fetch),
        .mainline_resume (mainline_resume),
        .tmr_add_valid   (tmr_add_valid),
        .tmr_add_val     (tmr_add_val)
    );

endmodule

// File: tb/tb_irq_seq_top.sv
module tb_irq_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int EV_FETCH = 1;
    localparam int EV_TMR   = 2;
    localparam int EV_RES   = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq_pend, irq_portb, sync_on, core_busy;
    logic        gie_set, gie_clr, spd_wr, vec_wr, ret_valid;
    logic [3:0]  spd_wdata, int_spd;
    logic [15:0] vec_wdata, ret_pc;
    logic [2:0]  ret_opt;
    logic [7:0]  w_val;
    logic        gie, vec_fetch, mainline_resume, tmr_add_valid, stack_ovf;
    logic [3:0]  spd_code;
    logic [15:0] vec_addr;
    logic [7:0]  tmr_add_val;
    logic [1:0]  nest_depth;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct packed {
        int kind;
        int at;
        int val;
    } exp_t;
    exp_t exp_q[$];

    irq_seq_top dut (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_portb(irq_portb),
        .sync_on(sync_on), .core_busy(core_busy), .gie_set(gie_set), .gie_clr(gie_clr),
        .spd_wr(spd_wr), .spd_wdata(spd_wdata), .int_spd(int_spd), .vec_wr(vec_wr),
        .vec_wdata(vec_wdata), .ret_valid(ret_valid), .ret_opt(ret_opt), .ret_pc(ret_pc),
        .w_val(w_val), .gie(gie), .spd_code(spd_code), .vec_addr(vec_addr),
        .vec_fetch(vec_fetch), .mainline_resume(mainline_resume),
        .tmr_add_valid(tmr_add_valid), .tmr_add_val(tmr_add_val),
        .nest_depth(nest_depth), .stack_ovf(stack_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic expect_ev(input int kind, input int at, input int val);
        exp_t e;
        e.kind = kind; e.at = at; e.val = val;
        exp_q.push_back(e);
    endtask

    task automatic mon_ev(input int kind, input int val);
        exp_t e;
        if (exp_q.size() == 0) begin
            chk("R1/R10/R11 unexpected event", kind, 0);
        end else begin
            e = exp_q.pop_front();
            chk("R1/R10/R11 event kind", kind, e.kind);
            chk("R1/R10/R11 event cycle", cyc, e.at);
            chk("R9/R10 event value", val, e.val);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (vec_fetch)       mon_ev(EV_FETCH, int'(vec_addr));
            if (tmr_add_valid)   mon_ev(EV_TMR, int'(tmr_add_val));
            if (mainline_resume) mon_ev(EV_RES, 0);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_gie_set();
        gie_set = 1'b1; step(1); gie_set = 1'b0;
    endtask

    task automatic enter(input logic pb, input int lat, input int expv);
        irq_portb = pb; irq_pend = 1'b1;
        expect_ev(EV_FETCH, cyc + lat, expv);
        step(1);
        irq_pend = 1'b0; irq_portb = 1'b0;
    endtask

    task automatic do_ret(input logic [2:0] opt, input logic [15:0] pc, input logic [7:0] w);
        ret_valid = 1'b1; ret_opt = opt; ret_pc = pc; w_val = w;
        if (opt[0]) expect_ev(EV_TMR, cyc + 1, int'(w));
        expect_ev(EV_RES, cyc + 3, 0);
        step(1);
        ret_valid = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; irq_pend = 0; irq_portb = 0; sync_on = 0; core_busy = 0;
        gie_set = 0; gie_clr = 0; spd_wr = 0; vec_wr = 0; ret_valid = 0;
        spd_wdata = '0; int_spd = 4'hA; vec_wdata = '0; ret_pc = '0; ret_opt = '0; w_val = '0;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R13 reset state
        chk("R13 gie", gie, 0);
        chk("R13 spd_code", spd_code, 4'h7);
        chk("R13 vec_addr", vec_addr, 16'h0040);
        chk("R13 depth", nest_depth, 0);
        chk("R13 ovf", stack_ovf, 0);
        chk("R13 strobes", {vec_fetch, mainline_resume, tmr_add_valid}, 0);

        spd_wr = 1; spd_wdata = 4'h3; step(1); spd_wr = 0;
        chk("R8 mainline speed write", spd_code, 4'h3);

        // R5: no acceptance with gie=0
        irq_pend = 1; step(4); irq_pend = 0;
        chk("R5 no entry while gie=0", nest_depth, 0);

        // R1 / R4 plain entry
        pulse_gie_set();
        enter(1'b0, 3, 16'h0040);
        chk("R4 gie cleared", gie, 0);
        chk("R4 speed swapped", spd_code, 4'hA);
        chk("R4 depth", nest_depth, 1);
        step(3);
        // R7 R8 R9 R10 return with all options
        do_ret(3'b111, 16'h1234, 8'h55);
        chk("R7 gie set on return", gie, 1);
        chk("R8 speed restored", spd_code, 4'h3);
        chk("R9 vector pc+1", vec_addr, 16'h1235);
        chk("R8 pop depth", nest_depth, 0);
        step(3);

        // R2 port-B slow path
        sync_on = 0;
        enter(1'b1, 5, 16'h1235);
        step(5);
        gie_clr = 1; step(1); gie_clr = 0;
        do_ret(3'b000, 16'h2000, 8'h11);
        chk("R7 gie set despite clear", gie, 1);
        chk("R8 speed kept", spd_code, 4'hA);
        chk("R9 vector unchanged", vec_addr, 16'h1235);
        step(3);

        // R2 synchronizer on, then R5/R6 nesting
        spd_wr = 1; spd_wdata = 4'h3; step(1); spd_wr = 0;
        sync_on = 1;
        enter(1'b1, 3, 16'h1235);
        step(3);
        pulse_gie_set();
        enter(1'b0, 3, 16'h1235);
        chk("R5 nested depth", nest_depth, 2);
        step(3);
        pulse_gie_set();
        irq_pend = 1; step(4); irq_pend = 0;
        chk("R6 overflow flagged", stack_ovf, 1);
        chk("R6 depth held", nest_depth, 2);
        do_ret(3'b100, 16'h0, 8'h0);
        chk("R6 inner saved code", spd_code, 4'hA);
        chk("R6 depth after pop", nest_depth, 1);
        step(3);
        do_ret(3'b100, 16'h0, 8'h0);
        chk("R6 outer saved code", spd_code, 4'h3);
        chk("R6 ovf sticky", stack_ovf, 1);
        step(3);

        // R3 busy blocks entry
        core_busy = 1; irq_pend = 1;
        expect_ev(EV_FETCH, cyc + 7, 16'h1235);
        step(2);
        chk("R3 no entry while busy", nest_depth, 0);
        step(2);
        core_busy = 0;
        step(1);
        irq_pend = 0;
        chk("R3 taken after busy", nest_depth, 1);
        step(3);

        // R11 request during return window; R9 wrap; R10 timer add
        ret_valid = 1; ret_opt = 3'b011; ret_pc = 16'hFFFF; w_val = 8'h09; irq_pend = 1;
        expect_ev(EV_TMR, cyc + 1, 8'h09);
        expect_ev(EV_RES, cyc + 3, 0);
        expect_ev(EV_FETCH, cyc + 7, 16'h0000);
        step(1);
        ret_valid = 0;
        chk("R9 vector wraps", vec_addr, 16'h0000);
        step(3);
        chk("R11 no entry in refill", nest_depth, 0);
        step(1);
        irq_pend = 0;
        chk("R11 pending taken after refill", nest_depth, 1);
        step(3);
        do_ret(3'b000, 16'h0, 8'h0);
        step(3);

        // R12 return outside handler; R9 direct write
        gie_clr = 1; step(1); gie_clr = 0;
        ret_valid = 1; ret_opt = 3'b111; ret_pc = 16'h0500; w_val = 8'h77;
        step(1); ret_valid = 0;
        step(3);
        chk("R12 gie unchanged", gie, 0);
        chk("R12 vector unchanged", vec_addr, 16'h0000);
        chk("R12 speed unchanged", spd_code, 4'hA);
        chk("R12 depth unchanged", nest_depth, 0);
        vec_wr = 1; vec_wdata = 16'h0200; step(1); vec_wr = 0;
        chk("R9 direct vector write", vec_addr, 16'h0200);

        step(2);
        chk("R1 all expected events seen", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule